// File: doc/BRIEF.md
# Dual Halfword Multiply with 64-bit Accumulate

This unit takes two 32-bit operands and treats each as a pair of signed 16-bit halfwords. It multiplies the low halfwords together and the high halfwords together, combines the two products as either a sum or a difference, and adds that signed value into a 64-bit accumulator. The accumulator enters and leaves the unit as a low 32-bit word and a high 32-bit word. A select input can exchange the two halfwords of the second operand before the multiplies, which pairs each low half with the other operand's high half.

The datapath sits behind a register file and an instruction decoder in a processor execute stage. The decoder supplies the operand words, the current accumulator pair and the two mode selects together with a valid strobe. Two clock cycles later the unit presents the new low and high words with its own valid strobe, so that they can be written back. One new operation can start on every clock.

Top module: `dual_mac_long`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and both result words are 0.
- R2: With `xchg_sel` low, product one is signed `op_a[15:0]` times signed `op_b[15:0]`, and product two is signed `op_a[31:16]` times signed `op_b[31:16]`.
- R3: With `xchg_sel` high, `op_b[15:0]` and `op_b[31:16]` trade places before the multiplies, so product one uses `op_b[31:16]` and product two uses `op_b[15:0]`.
- R4: With `diff_sel` low, product one plus product two is added to the accumulator. With `diff_sel` high, product one minus product two is added.
- R5: The accumulator is `{acc_hi_in, acc_lo_in}`, with `acc_lo_in` in bits 31:0 and `acc_hi_in` in bits 63:32. The result is split the same way: `res_lo` is bits 31:0 and `res_hi` is bits 63:32. A carry or borrow crosses between the two words.
- R6: The sum or difference of the products is kept at full precision and sign-extended before it is accumulated. For example, 0x8000 times 0x8000 in both lanes adds +2^31 and does not add a negative value.
- R7: The 64-bit addition wraps modulo 2^64. No flag or saturation is produced.
- R8: `out_valid` goes high exactly two clock edges after the edge that samples `in_valid` high. Back-to-back valid inputs give back-to-back results in the same order.
- R9: When no operation completes on an edge, `res_lo` and `res_hi` hold their previous values and `out_valid` is 0, whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Starts an operation with the inputs presented this cycle |
| op_a | input | 32 | First operand, two signed halfwords |
| op_b | input | 32 | Second operand, two signed halfwords, optionally exchanged |
| acc_lo_in | input | 32 | Accumulator bits 31:0 |
| acc_hi_in | input | 32 | Accumulator bits 63:32 |
| xchg_sel | input | 1 | 1 exchanges the halfwords of `op_b` |
| diff_sel | input | 1 | 0 adds the product sum, 1 adds product one minus product two |
| out_valid | output | 1 | Result words are new on this cycle |
| res_lo | output | 32 | Result bits 31:0 |
| res_hi | output | 32 | Result bits 63:32 |

## Verification
The hardest case to reach is the one where the 33-bit product combination matters: both lanes at 0x8000 times 0x8000 give +2^31. A 32-bit intermediate would read this as negative and would corrupt the high word. The bench drives this corner on purpose with every combination of `xchg_sel` and `diff_sel`, and with accumulators chosen to push a carry into the high word and a wrap through 2^64. A behavioural model in the bench uses 64-bit integer arithmetic and a two-deep queue to predict both words and the valid strobe on every clock. Idle cycles with the data inputs changing check that the outputs hold.

// File: rtl/dml_pkg.sv
package dml_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;
  localparam int PROD_W = 2 * HALF_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int ACC_W  = 2 * WORD_W;

  typedef enum logic {
    COMB_SUM  = 1'b0,
    COMB_DIFF = 1'b1
  } comb_mode_e;
endpackage

// File: rtl/dml_operand_prep.sv
module dml_operand_prep #(
  parameter int HW = 16
) (
  input  logic [2*HW-1:0] a_word,
  input  logic [2*HW-1:0] b_word,
  input  logic            exchange,
  output logic [HW-1:0]   a_half [2],
  output logic [HW-1:0]   b_half [2]
);
  logic [HW-1:0] b_raw [2];

  for (genvar g = 0; g < 2; g++) begin : g_split
    assign a_half[g] = a_word[g*HW +: HW];
    assign b_raw[g]  = b_word[g*HW +: HW];
  end

  // Lane 0 pairs with b lane 1 when exchanged, and lane 1 with b lane 0.
  always_comb begin
    if (exchange) begin
      b_half[0] = b_raw[1];
      b_half[1] = b_raw[0];
    end else begin
      b_half[0] = b_raw[0];
      b_half[1] = b_raw[1];
    end
  end
endmodule

// File: rtl/dml_lane_mult.sv
module dml_lane_mult #(
  parameter int HW = 16,
  localparam int PW = 2 * HW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [HW-1:0]        a_in,
  input  logic [HW-1:0]        b_in,
  output logic signed [PW-1:0] prod
);
  logic signed [HW-1:0] a_s;
  logic signed [HW-1:0] b_s;

  assign a_s = a_in;
  assign b_s = b_in;

  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else if (en) prod <= a_s * b_s;
  end

  localparam logic signed [PW-1:0] PROD_MAX = PW'(1) <<< (PW - 2);
  localparam logic signed [PW-1:0] PROD_MIN = -(PROD_MAX - (PW'(1) <<< (HW - 1)));

  AST_PROD_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    en |=> (prod <= PROD_MAX && prod >= PROD_MIN)); // R6
endmodule

// File: rtl/dml_accum.sv
module dml_accum #(
  parameter int PW = 32,
  parameter int AW = 64,
  localparam int SW = PW + 1,
  localparam int WW = AW / 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  input  logic                 s_diff,
  input  logic signed [PW-1:0] p_one,
  input  logic signed [PW-1:0] p_two,
  input  logic [AW-1:0]        acc,
  output logic                 out_valid,
  output logic [WW-1:0]        res_lo,
  output logic [WW-1:0]        res_hi
);
  import dml_pkg::*;

  logic signed [SW-1:0] x_one, x_two, combo;
  logic [AW-1:0]        combo_ext;
  logic [AW-1:0]        total;
  comb_mode_e           mode;

  assign mode  = comb_mode_e'(s_diff);
  assign x_one = {p_one[PW-1], p_one};
  assign x_two = {p_two[PW-1], p_two};

  always_comb begin
    case (mode)
      COMB_DIFF: combo = x_one - x_two;
      default:   combo = x_one + x_two;
    endcase
  end

  assign combo_ext = {{(AW-SW){combo[SW-1]}}, combo};
  assign total     = acc + combo_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      out_valid <= s_valid;
      if (s_valid) begin
        res_lo <= total[WW-1:0];
        res_hi <= total[AW-1:WW];
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    s_valid |=> out_valid); // R8
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !s_valid |=> ($stable(res_lo) && $stable(res_hi))); // R9
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (s_valid && p_one == '0 && p_two == '0) |=> ({res_hi, res_lo} == $past(acc))); // R5
endmodule

// File: rtl/dual_mac_long.sv
module dual_mac_long #(
  parameter int HALF_W = dml_pkg::HALF_W,
  localparam int WORD_W = 2 * HALF_W,
  localparam int PROD_W = 2 * HALF_W,
  localparam int ACC_W  = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic [WORD_W-1:0] acc_lo_in,
  input  logic [WORD_W-1:0] acc_hi_in,
  input  logic              xchg_sel,
  input  logic              diff_sel,
  output logic              out_valid,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi
);
  logic [HALF_W-1:0]        a_half [2];
  logic [HALF_W-1:0]        b_half [2];
  logic signed [PROD_W-1:0] prod   [2];

  logic             s1_valid;
  logic             s1_diff;
  logic [ACC_W-1:0] s1_acc;

  dml_operand_prep #(.HW(HALF_W)) u_prep (
    .a_word   (op_a),
    .b_word   (op_b),
    .exchange (xchg_sel),
    .a_half   (a_half),
    .b_half   (b_half)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    dml_lane_mult #(.HW(HALF_W)) u_mult (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .a_in (a_half[g]),
      .b_in (b_half[g]),
      .prod (prod[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_diff  <= 1'b0;
      s1_acc   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_diff <= diff_sel;
        s1_acc  <= {acc_hi_in, acc_lo_in};
      end
    end
  end

  dml_accum #(.PW(PROD_W), .AW(ACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .s_valid   (s1_valid),
    .s_diff    (s1_diff),
    .p_one     (prod[0]),
    .p_two     (prod[1]),
    .acc       (s1_acc),
    .out_valid (out_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi)
  );

  AST_STAGE_ONE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && res_lo == '0 && res_hi == '0)); // R1
endmodule

// File: tb/tb_dual_mac_long.sv
module tb_dual_mac_long;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_lo_in = '0, acc_hi_in = '0;
  logic        xchg_sel = 1'b0, diff_sel = 1'b0;
  logic        out_valid;
  logic [31:0] res_lo, res_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  dual_mac_long dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_lo_in(acc_lo_in), .acc_hi_in(acc_hi_in), .xchg_sel(xchg_sel),
    .diff_sel(diff_sel), .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit          v;
    logic [63:0] r;
    string       tag;
  } ent_t;

  ent_t q0, q1;
  bit          exp_v;
  logic [63:0] exp_r;
  string       exp_tag;

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [63:0] acc, input bit x, input bit d);
    logic [31:0] bb;
    longint p1, p2, e;
    bb = x ? {b[15:0], b[31:16]} : b;
    p1 = longint'($signed(a[15:0])) * longint'($signed(bb[15:0]));
    p2 = longint'($signed(a[31:16])) * longint'($signed(bb[31:16]));
    e  = d ? (p1 - p2) : (p1 + p2);
    return acc + 64'(e);
  endfunction

  task automatic compare();
    n_cmp++;
    if (out_valid !== exp_v) begin
      n_bad++;
      $display("FAIL R8 out_valid actual=%0b expected=%0b", out_valid, exp_v);
    end
    n_cmp++;
    if ({res_hi, res_lo} !== exp_r) begin
      n_bad++;
      $display("FAIL %s result actual=%h_%h expected=%h", exp_v ? exp_tag : "R9",
               res_hi, res_lo, exp_r);
    end
  endtask

  task automatic cycle(input bit v, input logic [31:0] a, input logic [31:0] b,
                       input logic [63:0] acc, input bit x, input bit d, input string tag);
    @(negedge clk);
    in_valid = v; op_a = a; op_b = b; acc_lo_in = acc[31:0]; acc_hi_in = acc[63:32];
    xchg_sel = x; diff_sel = d;
    exp_v = q1.v;
    if (q1.v) begin exp_r = q1.r; exp_tag = q1.tag; end
    q1 = q0;
    q0.v = v; q0.r = v ? model(a, b, acc, x, d) : 64'h0; q0.tag = tag;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      cycle(1'b0, $urandom, $urandom, {$urandom, $urandom}, i[0], i[1], "R9");
  endtask

  initial begin
    q0 = '{0, 64'h0, ""}; q1 = '{0, 64'h0, ""};
    exp_v = 0; exp_r = '0; exp_tag = "R1";
    repeat (3) @(negedge clk);
    // R1: outputs cleared while in reset
    n_cmp++;
    if (out_valid !== 1'b0 || res_lo !== '0 || res_hi !== '0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%b %h %h expected=0 0 0", out_valid, res_hi, res_lo);
    end
    rst = 1'b0;

    // R2 plain lanes, R3 exchange with distinct halves
    cycle(1, 32'h0003_0002, 32'h0007_0005, 64'h0, 0, 0, "R2");
    cycle(1, 32'hFFFE_0004, 32'h0009_FFFD, 64'h10, 0, 0, "R2");
    cycle(1, 32'h0003_0002, 32'h0007_0005, 64'h0, 1, 0, "R3");
    cycle(1, 32'h1234_8765, 32'hA5A5_0F0F, 64'h0, 1, 1, "R3");
    // R4 difference mode
    cycle(1, 32'h0010_0020, 32'h0030_0040, 64'h100, 0, 1, "R4");
    cycle(1, 32'h7FFF_8001, 32'h8000_7FFF, 64'h0, 0, 1, "R4");
    idle(3);
    // R6 extreme 0x8000*0x8000 in both lanes, all mode combinations
    for (int m = 0; m < 4; m++)
      cycle(1, 32'h8000_8000, 32'h8000_8000, 64'h0, m[0], m[1], "R6");
    cycle(1, 32'h8000_8000, 32'h8000_8000, 64'h0000_0000_8000_0000, 0, 0, "R6");
    cycle(1, 32'h8000_8000, 32'h8000_8000, 64'h0000_0001_0000_0000, 1, 1, "R6");
    // R5 carry and borrow across the word boundary
    cycle(1, 32'h0000_0001, 32'h0000_0001, 64'h0000_0000_FFFF_FFFF, 0, 0, "R5");
    cycle(1, 32'h0000_0001, 32'h0000_FFFF, 64'h0000_0001_0000_0000, 0, 0, "R5");
    // R7 wrap through 2^64 in both directions
    cycle(1, 32'h0000_0001, 32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R7");
    cycle(1, 32'h0000_0001, 32'h0000_FFFF, 64'h0, 0, 0, "R7");
    idle(4);
    // R8 back-to-back stream, R9 gaps in between
    for (int i = 0; i < 300; i++) begin
      bit v;
      v = ($urandom % 4) != 0;
      cycle(v, $urandom, $urandom, {$urandom, $urandom}, 1'($urandom), 1'($urandom),
            v ? "R8" : "R9");
    end
    idle(4);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule